// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of month, month, day of week and a two-digit year. A sub-second prescaler counts pulses of a slow timebase enable (by default 32768 pulses per second) and produces one step per second. Each step carries upward through the fields. Month lengths and leap years are handled, and years 00 to 99 are taken as 2000 to 2099.

The hours field works in either a 24-hour or a 12-hour form. Its top bit selects the form. In the 12-hour form, bit 5 is the PM flag. A halt flag in the seconds field freezes all counting. A host interface presets any field through a parallel load port. Writing the seconds field also restarts the sub-second prescaler, so the first full second after a time set is a whole second long. Preset values outside the legal range are not corrected, but every field still rolls over, so a bad preset cannot lock the counter.

Top module: `bcd_rtc_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour form), date 01, month 01, day of week 01 and year 00. The prescaler starts from zero.
- R2: While running, the seconds field advances by one exactly when the TICKS_PER_SEC-th `tick_en` pulse since the last second boundary is seen.
- R3: Writing the seconds field clears the prescaler. After such a write, exactly TICKS_PER_SEC further `tick_en` pulses are needed before the next advance.
- R4: Bit 7 of the seconds field is a halt flag. While it is 1, no field advances and the prescaler is frozen. Writing the seconds field with bit 7 clear resumes counting.
- R5: Seconds and minutes count 00 to 59 in BCD. Wrapping from 59 to 00 carries into the next field.
- R6: With hours bit 7 = 0, hours count 00 to 23 in BCD with bits 7:6 zero. The step from 23 to 00 advances the date.
- R7: With hours bit 7 = 1, bits 4:0 hold the hour 12, 01 to 11 in BCD and bit 5 is PM (1 = PM). The flag flips on the step from 11 to 12. The date advances only on the step from 11 PM to 12 AM.
- R8: The date wraps to 01 after 31, 30 or 28/29 depending on the month. February has 29 days when the two-digit year is divisible by 4.
- R9: The month wraps from 12 to 01 and then increments the BCD year. The year wraps from 99 to 00.
- R10: Day of week increments whenever the date advances and wraps from 7 to 1.
- R11: When `wr_en` is high, `wr_sel` picks the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. The value appears on the output the next cycle. Code 7 changes nothing. A write cycle drops any second step that would have fallen in that cycle.
- R12: A field holding a value at or above its last legal value behaves like the last value: on its next step it wraps to its first value and carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sub-second timebase enable pulse |
| wr_en | input | 1 | Load strobe for one field |
| wr_sel | input | 3 | Field code for the load |
| wr_data | input | 8 | Packed BCD value to load |
| sec_o | output | 8 | Halt flag (bit 7) and seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Mode bit, PM/20-hour bit and hour digits |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| wday_o | output | 8 | Day of week 1 to 7 |
| year_o | output | 8 | Two-digit year |

## Verification
A wrong prescaler count shows on `sec_o` at the first second boundary, one pulse early or late. A wrong month-length or leap decision only shows at the last day of the affected month, when `date_o` fails to wrap or wraps a day early. For that reason every month of every year is preset to its last day and the day before, and one step is taken. A broken 12-hour PM flip or date carry only shows at the hour boundaries, so every hour of the day is stepped in both hour forms, each hour checked right after its step.

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] wday_o,
  output logic [7:0] year_o
);
  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST_TICK = PW'(TICKS_PER_SEC - 1);
  localparam logic [2:0] SEL_SEC = 3'd0, SEL_MIN = 3'd1, SEL_HOUR = 3'd2,
                         SEL_DATE = 3'd3, SEL_MON = 3'd4, SEL_WDAY = 3'd5, SEL_YEAR = 3'd6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic [PW-1:0] presc_q;
  logic [7:0] sec_q, min_q, hour_q, date_q, month_q, wday_q, year_q;

  wire halt = sec_q[7];
  wire step = tick_en && !halt && (presc_q == LAST_TICK) && !wr_en;

  wire sec_wrap  = sec_q[6:0] >= 7'h59;
  wire min_wrap  = min_q >= 8'h59;
  wire mode12    = hour_q[7];
  wire end24     = hour_q[5:0] >= 6'h23;
  wire at11      = hour_q[4:0] == 5'h11;
  wire day_end   = mode12 ? (at11 && hour_q[5]) : end24;
  wire leap      = year_q[4] ? (year_q[3:0] == 4'd2 || year_q[3:0] == 4'd6)
                             : (year_q[3:0] == 4'd0 || year_q[3:0] == 4'd4 || year_q[3:0] == 4'd8);
  wire short_mon = (month_q == 8'h04) || (month_q == 8'h06) || (month_q == 8'h09) || (month_q == 8'h11);
  wire [7:0] last_date = (month_q == 8'h02) ? (leap ? 8'h29 : 8'h28) : (short_mon ? 8'h30 : 8'h31);

  wire c_min   = step && sec_wrap;
  wire c_hour  = c_min && min_wrap;
  wire c_day   = c_hour && day_end;
  wire c_month = c_day && (date_q >= last_date);
  wire c_year  = c_month && (month_q >= 8'h12);

  wire [7:0] sec_inc = bcd_inc({1'b0, sec_q[6:0]});
  wire [7:0] hr_inc  = bcd_inc({2'b00, hour_q[5:0]});
  wire [7:0] h12_inc = bcd_inc({3'b000, hour_q[4:0]});
  logic [7:0] hour_next;

  always_comb begin
    if (!mode12)
      hour_next = end24 ? 8'h00 : (hr_inc & 8'h3F);
    else if (at11)
      hour_next = {2'b10, ~hour_q[5], 5'h12};
    else if (hour_q[4:0] >= 5'h12)
      hour_next = {2'b10, hour_q[5], 5'h01};
    else
      hour_next = {2'b10, hour_q[5], 5'h00} | (h12_inc & 8'h1F);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      sec_q   <= 8'h00;
      min_q   <= 8'h00;
      hour_q  <= 8'h00;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      wday_q  <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (wr_en && wr_sel == SEL_SEC)
        presc_q <= '0;
      else if (tick_en && !halt)
        presc_q <= (presc_q == LAST_TICK) ? '0 : presc_q + PW'(1);

      if (wr_en) begin
        case (wr_sel)
          SEL_SEC:  sec_q   <= wr_data;
          SEL_MIN:  min_q   <= wr_data;
          SEL_HOUR: hour_q  <= wr_data;
          SEL_DATE: date_q  <= wr_data;
          SEL_MON:  month_q <= wr_data;
          SEL_WDAY: wday_q  <= wr_data;
          SEL_YEAR: year_q  <= wr_data;
          default: ;
        endcase
      end else begin
        if (step)    sec_q   <= sec_wrap ? 8'h00 : sec_inc;
        if (c_min)   min_q   <= min_wrap ? 8'h00 : bcd_inc(min_q);
        if (c_hour)  hour_q  <= hour_next;
        if (c_day)   date_q  <= (date_q >= last_date) ? 8'h01 : bcd_inc(date_q);
        if (c_day)   wday_q  <= (wday_q >= 8'h07) ? 8'h01 : wday_q + 8'h01;
        if (c_month) month_q <= (month_q >= 8'h12) ? 8'h01 : bcd_inc(month_q);
        if (c_year)  year_q  <= (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
      end
    end
  end

  assign sec_o   = sec_q;
  assign min_o   = min_q;
  assign hour_o  = hour_q;
  assign date_o  = date_q;
  assign month_o = month_q;
  assign wday_o  = wday_q;
  assign year_o  = year_q;

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                          $stable(date_o) && $stable(month_o) && $stable(year_o)));
  // R11
  load_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SEC) |=> (sec_o == $past(wr_data)));
  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sec_q == 8'h59) |=> (sec_o == 8'h00));
  // R10
  wday_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !c_day) |=> $stable(wday_o));
  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_HOUR) |=> $stable(hour_o[7]));
  // R8
  date_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_month |=> (date_o == 8'h01));
endmodule

// File: tb/bcd_rtc_counter_bench.sv
`timescale 1ns/1ps
module bcd_rtc_counter_bench;
  localparam int T = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  bcd_rtc_counter #(.TICKS_PER_SEC(T)) u_bcd_rtc_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .wday_o(wday_o), .year_o(year_o));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int last_day(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc_hour(input int h, input bit m12);
    logic [7:0] b;
    if (!m12) return to_bcd(h);
    b = to_bcd((h % 12 == 0) ? 12 : h % 12);
    return {2'b10, (h >= 12) ? 1'b1 : 1'b0, b[4:0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin tick_en = 1'b1; @(negedge clk); end
    tick_en = 1'b0;
  endtask

  task automatic load_all(input logic [7:0] y, mo, d, wd, h, mi, s);
    wr(3'd6, y); wr(3'd4, mo); wr(3'd3, d); wr(3'd5, wd);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] snap [7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sec", sec_o, 8'h00);   chk("R1 min", min_o, 8'h00);
    chk("R1 hour", hour_o, 8'h00); chk("R1 date", date_o, 8'h01);
    chk("R1 month", month_o, 8'h01); chk("R1 wday", wday_o, 8'h01);
    chk("R1 year", year_o, 8'h00);
    ticks(T - 1); chk("R1 prescaler from zero", sec_o, 8'h00);
    ticks(1);     chk("R2 first second", sec_o, 8'h01);

    wr(3'd0, 8'h00);
    ticks(T - 1); chk("R2 early", sec_o, 8'h00);
    ticks(1);     chk("R2 on time", sec_o, 8'h01);

    ticks(2); wr(3'd0, 8'h20);
    ticks(T - 1); chk("R3 prescaler cleared", sec_o, 8'h20);
    ticks(1);     chk("R3 full second", sec_o, 8'h21);

    wr(3'd0, 8'hC2);
    ticks(3 * T); chk("R4 halted sec", sec_o, 8'hC2);
    wr(3'd0, 8'h42);
    ticks(T);     chk("R4 resumed", sec_o, 8'h43);

    for (int s = 0; s < 60; s++) begin
      load_all(8'h24, 8'h03, 8'h10, 8'h02, 8'h10, 8'h07, to_bcd(s));
      ticks(T);
      chk("R5 sec", sec_o, to_bcd((s + 1) % 60));
      chk("R5 min carry", min_o, (s == 59) ? 8'h08 : 8'h07);
    end

    for (int m12 = 0; m12 < 2; m12++) begin
      for (int h = 0; h < 24; h++) begin
        load_all(8'h24, 8'h05, 8'h15, 8'h03, enc_hour(h, m12[0]), 8'h59, 8'h59);
        ticks(T);
        if (m12 == 0) chk("R6 hour", hour_o, enc_hour((h + 1) % 24, 1'b0));
        else          chk("R7 hour", hour_o, enc_hour((h + 1) % 24, 1'b1));
        chk(m12 ? "R7 date carry" : "R6 date carry", date_o, (h == 23) ? 8'h16 : 8'h15);
        chk("R5 min wrap", min_o, 8'h00);
        chk("R10 wday at midnight", wday_o, (h == 23) ? 8'h04 : 8'h03);
      end
    end

    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int l, wd;
        l = last_day(m, y);
        wd = (y + m) % 7 + 1;
        load_all(to_bcd(y), to_bcd(m), to_bcd(l - 1), to_bcd(wd), 8'h23, 8'h59, 8'h59);
        ticks(T);
        chk("R8 day before last", date_o, to_bcd(l));
        chk("R8 month kept", month_o, to_bcd(m));
        load_all(to_bcd(y), to_bcd(m), to_bcd(l), to_bcd(wd), 8'h23, 8'h59, 8'h59);
        ticks(T);
        chk("R8 date wrap", date_o, 8'h01);
        chk("R9 month", month_o, to_bcd((m == 12) ? 1 : m + 1));
        chk("R9 year", year_o, to_bcd((m == 12) ? (y + 1) % 100 : y));
        chk("R10 wday", wday_o, to_bcd((wd == 7) ? 1 : wd + 1));
      end
    end

    snap[0] = sec_o; snap[1] = min_o; snap[2] = hour_o; snap[3] = date_o;
    snap[4] = month_o; snap[5] = wday_o; snap[6] = year_o;
    wr(3'd7, 8'h55);
    chk("R11 code7 sec", sec_o, snap[0]);   chk("R11 code7 min", min_o, snap[1]);
    chk("R11 code7 hour", hour_o, snap[2]); chk("R11 code7 date", date_o, snap[3]);
    chk("R11 code7 month", month_o, snap[4]); chk("R11 code7 wday", wday_o, snap[5]);
    chk("R11 code7 year", year_o, snap[6]);

    wr(3'd0, 8'h10);
    ticks(T - 1);
    tick_en = 1'b1; wr(3'd1, 8'h33); tick_en = 1'b0;
    chk("R11 step dropped", sec_o, 8'h10);
    chk("R11 min loaded", min_o, 8'h33);
    ticks(T); chk("R11 next second", sec_o, 8'h11);

    load_all(8'h30, 8'h06, 8'h12, 8'h01, 8'h05, 8'h10, 8'h6A);
    ticks(T);
    chk("R12 bad sec wraps", sec_o, 8'h00);
    chk("R12 bad sec carries", min_o, 8'h11);
    load_all(8'h30, 8'h06, 8'h12, 8'h01, 8'h3F, 8'h59, 8'h59);
    ticks(T);
    chk("R12 bad hour wraps", hour_o, 8'h00);
    chk("R12 bad hour carries", date_o, 8'h13);
    load_all(8'h30, 8'h1F, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(T);
    chk("R12 bad month date", date_o, 8'h01);
    chk("R12 bad month wraps", month_o, 8'h01);
    chk("R12 bad month carries", year_o, 8'h31);
    load_all(8'h30, 8'h06, 8'h12, 8'h01, 8'hB5, 8'h59, 8'h59);
    ticks(T);
    chk("R12 bad 12h hour", hour_o, 8'hA1);
    chk("R12 bad 12h no date", date_o, 8'h12);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule